// File: doc/BRIEF.md
# Three-Slot Cartridge Bank Mapper

This block sits between an 8-bit CPU and a game cartridge. It turns each 16-bit CPU address into a strobe and address for one of three memories outside the block: the cartridge ROM, a 32 KB cartridge RAM, or an 8 KB on-board work RAM. The lower 48 KB of CPU space is split into three 16 KB slots. Each slot shows one ROM page, and a paging register picks that page. The CPU writes the paging registers by storing to the top four bytes of the address space.

A control register can swap the third slot (8000–BFFF) for one of two 16 KB halves of cartridge RAM, for both reads and writes. The first kilobyte of CPU space always reads the first kilobyte of ROM, so the reset and interrupt entry points stay reachable whatever page slot 0 holds. Page numbers are cut to the ROM size, which is a parameter rounded up to a power of two. The work RAM repeats across C000–FFFF. A write that reaches a paging register is also stored in work RAM.

Every access presented on a clock edge gives registered outputs on that edge. A paging write takes effect for accesses presented on later cycles.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the registers hold ctl=0, slot0=0, slot1=1, slot2=2. A read of any address in 0000–BFFF then returns rom_addr equal to the CPU address.
- R2: A read of 0000–03FF always gives rom_addr = {zeros, addr[9:0]}, whatever the slot-0 page holds.
- R3: A write to FFFD sets the slot-0 page. A read of 0400–3FFF then gives rom_addr = {page, addr[13:0]}.
- R4: A write to FFFE sets the slot-1 page, used for 4000–7FFF. A write to FFFF sets the slot-2 page, used for 8000–BFFF. Both form rom_addr as {page, addr[13:0]}.
- R5: Only the low log2(ROM_BYTES)−14 bits of a page value are used. With the default 256 KB ROM, a page value of 0x13 selects page 3 and 0xFF selects page 15.
- R6: Writing FFFC with bit 3 set maps 8000–BFFF to cartridge RAM for reads (cram_sel) and writes (cram_sel and cram_we), with cram_addr = {FFFC bit 2, addr[13:0]}. Clearing bit 3 brings back the slot-2 ROM page.
- R7: A write to FFFC–FFFF also gives a work-RAM write (wram_sel=1, wram_we=1) at wram_addr = addr[12:0].
- R8: A write to any address other than FFFC–FFFF, FFF8–FFFB included, leaves every paging and control register unchanged.
- R9: Any access to C000–FFFF asserts wram_sel with wram_addr = addr[12:0], so the 8 KB repeats. wram_we follows the write flag.
- R10: A write to 0000–7FFF, or to 8000–BFFF while cartridge RAM is off, asserts no select and no write enable. rom_sel is asserted only for reads.
- R11: Outputs are registered with one cycle of latency. With cpu_req low, every select and write enable is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rom_sel | output | 1 | ROM read select |
| rom_addr | output | ROM_AW | ROM byte address |
| cram_sel | output | 1 | Cartridge RAM select |
| cram_we | output | 1 | Cartridge RAM write enable |
| cram_addr | output | 15 | Cartridge RAM byte address |
| wram_sel | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM byte address |

## Verification
Reads just after reset test the linear mapping, and reads inside and just outside the first kilobyte show the fixed window apart from the slot-0 page. Page values wider than the ROM show the masking. Writes to FFF8–FFFB and to ordinary addresses, each followed by reads of all three slots, show that only the top four bytes reach the registers. The cartridge RAM is tested in both halves and again after the overlay is switched off, and work-RAM accesses at several mirror offsets check the repeat.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int BANK_AW = 14;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_ROM  = 2'd1,
    RGN_CRAM = 2'd2,
    RGN_WRAM = 2'd3
  } region_e;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs #(
  parameter int SLOTS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [7:0]            wr_data,
  output logic [7:0]            ctl,
  output logic [SLOTS-1:0][7:0] pages
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= 8'h00;
      for (int i = 0; i < SLOTS; i++) pages[i] <= 8'(i);
    end else if (wr_en) begin
      if (wr_sel == 2'd0) ctl <= wr_data;
      for (int i = 0; i < SLOTS; i++)
        if (wr_sel == 2'(i + 1)) pages[i] <= wr_data;
    end
  end

  // R4
  page_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel == 2'd3 |=> pages[2] == $past(wr_data));
endmodule

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
(
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic        ram_on,
  output region_e     region,
  output logic [1:0]  slot,
  output logic        fixed_low
);
  always_comb begin
    slot      = addr[15:14];
    fixed_low = (addr[15:10] == 6'd0);
    region    = RGN_NONE;
    if (req) begin
      if (addr[15:14] == 2'b11)            region = RGN_WRAM;
      else if (addr[15:14] == 2'b10 && ram_on) region = RGN_CRAM;
      else if (!we)                        region = RGN_ROM;
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int ROM_BYTES  = 262144,
  parameter int WRAM_BYTES = 8192,
  parameter int ROM_AW     = $clog2(ROM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              cram_sel,
  output logic              cram_we,
  output logic [14:0]       cram_addr,
  output logic              wram_sel,
  output logic              wram_we,
  output logic [12:0]       wram_addr
);
  localparam int PG_W    = ROM_AW - BANK_AW;
  localparam int WRAM_AW = $clog2(WRAM_BYTES);
  localparam int SLOTS   = 3;

  logic [7:0]            ctl;
  logic [SLOTS-1:0][7:0] pages;
  logic                  reg_wr;
  region_e               region;
  logic [1:0]            slot;
  logic                  fixed_low;
  logic [7:0]            page_raw;
  logic [PG_W-1:0]       page_eff;

  assign reg_wr = cpu_req && cpu_we && (cpu_addr[15:2] == 14'h3FFF);

  cbm_regs #(.SLOTS(SLOTS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_sel(cpu_addr[1:0]),
    .wr_data(cpu_wdata), .ctl(ctl), .pages(pages)
  );

  cbm_decode u_dec (
    .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .ram_on(ctl[3]),
    .region(region), .slot(slot), .fixed_low(fixed_low)
  );

  always_comb begin
    case (slot)
      2'd0:    page_raw = pages[0];
      2'd1:    page_raw = pages[1];
      default: page_raw = pages[2];
    endcase
    page_eff = fixed_low ? '0 : page_raw[PG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_sel   <= 1'b0;
      rom_addr  <= '0;
      cram_sel  <= 1'b0;
      cram_we   <= 1'b0;
      cram_addr <= '0;
      wram_sel  <= 1'b0;
      wram_we   <= 1'b0;
      wram_addr <= '0;
    end else begin
      rom_sel   <= (region == RGN_ROM);
      rom_addr  <= {page_eff, cpu_addr[BANK_AW-1:0]};
      cram_sel  <= (region == RGN_CRAM);
      cram_we   <= (region == RGN_CRAM) && cpu_we;
      cram_addr <= {ctl[2], cpu_addr[BANK_AW-1:0]};
      wram_sel  <= (region == RGN_WRAM);
      wram_we   <= (region == RGN_WRAM) && cpu_we;
      wram_addr <= 13'(cpu_addr[WRAM_AW-1:0]);
    end
  end

  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_we && cpu_addr < 16'hFFFC |=> $stable(pages) && $stable(ctl));
  // R2
  low_window_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we && cpu_addr < 16'h0400 |=> rom_sel && rom_addr[ROM_AW-1:10] == '0);
  // R9
  wram_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_addr >= 16'hC000 |=> wram_sel && wram_addr == $past(cpu_addr[12:0]));
  // R10
  rom_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_we && cpu_addr < 16'h8000 |=> !rom_sel && !cram_sel && !wram_sel);
  // R11
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_sel, cram_sel, wram_sel}));
endmodule

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  localparam int ROM_AW = 18;

  typedef struct {
    logic              rs;
    logic [ROM_AW-1:0] ra;
    logic              cs;
    logic              cw;
    logic [14:0]       ca;
    logic              ws;
    logic              ww;
    logic [12:0]       wa;
    string             tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic rom_sel, cram_sel, cram_we, wram_sel, wram_we;
  logic [ROM_AW-1:0] rom_addr;
  logic [14:0] cram_addr;
  logic [12:0] wram_addr;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [7:0] m_ctl = 0, m_p0 = 0, m_p1 = 1, m_p2 = 2;
  bit done = 0;

  always #2 clk = ~clk;

  cart_bank_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_sel(rom_sel),
    .rom_addr(rom_addr), .cram_sel(cram_sel), .cram_we(cram_we),
    .cram_addr(cram_addr), .wram_sel(wram_sel), .wram_we(wram_we),
    .wram_addr(wram_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit req, input bit we, input logic [15:0] a,
                     input logic [7:0] d, input string tag);
    exp_t e;
    logic [7:0] pg;
    @(negedge clk);
    cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    e.rs = 0; e.ra = 0; e.cs = 0; e.cw = 0; e.ca = 0; e.ws = 0; e.ww = 0; e.wa = 0;
    e.tag = tag;
    if (req) begin
      if (a >= 16'hC000) begin
        e.ws = 1; e.ww = we; e.wa = a[12:0];
      end else if (a >= 16'h8000 && m_ctl[3]) begin
        e.cs = 1; e.cw = we; e.ca = {m_ctl[2], a[13:0]};
      end else if (!we) begin
        pg = (a < 16'h0400) ? 8'd0 : (a < 16'h4000) ? m_p0 : (a < 16'h8000) ? m_p1 : m_p2;
        e.rs = 1; e.ra = {pg[3:0], a[13:0]};
      end
      if (we) case (a)
        16'hFFFC: m_ctl = d;
        16'hFFFD: m_p0 = d;
        16'hFFFE: m_p1 = d;
        16'hFFFF: m_p2 = d;
        default: ;
      endcase
    end
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(rom_sel == e.rs && cram_sel == e.cs && cram_we == e.cw &&
            wram_sel == e.ws && wram_we == e.ww, {e.tag, " strobes"},
            {rom_sel, cram_sel, cram_we, wram_sel, wram_we},
            {e.rs, e.cs, e.cw, e.ws, e.ww});
        if (e.rs) chk(rom_addr == e.ra, {e.tag, " rom_addr"}, rom_addr, e.ra);
        if (e.cs) chk(cram_addr == e.ca, {e.tag, " cram_addr"}, cram_addr, e.ca);
        if (e.ws) chk(wram_addr == e.wa, {e.tag, " wram_addr"}, wram_addr, e.wa);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!rom_sel && !cram_sel && !wram_sel, "R11 reset strobes",
        {rom_sel, cram_sel, wram_sel}, 0);
    @(negedge clk); rst = 0;
    // R1 linear mapping after reset
    acc(1, 0, 16'h0123, 0, "R1");
    acc(1, 0, 16'h1234, 0, "R1");
    acc(1, 0, 16'h5678, 0, "R1");
    acc(1, 0, 16'h9ABC, 0, "R1");
    // R3 slot-0 page, R7 mirrored work RAM store
    acc(1, 1, 16'hFFFD, 8'h05, "R7");
    acc(1, 0, 16'h2000, 0, "R3");
    acc(1, 0, 16'h0400, 0, "R3");
    // R2 fixed low window
    acc(1, 0, 16'h0200, 0, "R2");
    acc(1, 0, 16'h03FF, 0, "R2");
    // R4
    acc(1, 1, 16'hFFFE, 8'h07, "R7");
    acc(1, 0, 16'h4001, 0, "R4");
    acc(1, 1, 16'hFFFF, 8'h09, "R7");
    acc(1, 0, 16'hBFFF, 0, "R4");
    // R5 masking
    acc(1, 1, 16'hFFFF, 8'h13, "R7");
    acc(1, 0, 16'h8010, 0, "R5");
    acc(1, 1, 16'hFFFE, 8'hFF, "R7");
    acc(1, 0, 16'h7FFF, 0, "R5");
    // R8 writes elsewhere leave registers alone
    acc(1, 1, 16'hFFFB, 8'h0A, "R8");
    acc(1, 1, 16'hFFF8, 8'h08, "R8");
    acc(1, 1, 16'hE000, 8'h08, "R8");
    acc(1, 0, 16'h8000, 0, "R8");
    acc(1, 0, 16'h4000, 0, "R8");
    acc(1, 0, 16'h3000, 0, "R8");
    // R10 writes to ROM space
    acc(1, 1, 16'h0000, 8'h55, "R10");
    acc(1, 1, 16'h5000, 8'h55, "R10");
    acc(1, 1, 16'h9000, 8'h55, "R10");
    // R6 cartridge RAM overlay
    acc(1, 1, 16'hFFFC, 8'h08, "R7");
    acc(1, 0, 16'h8005, 0, "R6");
    acc(1, 1, 16'hA000, 8'h11, "R6");
    acc(1, 1, 16'hFFFC, 8'h0C, "R7");
    acc(1, 0, 16'h8005, 0, "R6");
    acc(1, 1, 16'hBFFF, 8'h22, "R6");
    acc(1, 0, 16'h4005, 0, "R6");
    acc(1, 1, 16'hFFFC, 8'h00, "R7");
    acc(1, 0, 16'h8005, 0, "R6");
    acc(1, 1, 16'h8005, 8'h33, "R10");
    // R9 work RAM mirror
    acc(1, 0, 16'hC000, 0, "R9");
    acc(1, 0, 16'hE123, 0, "R9");
    acc(1, 1, 16'hDFFF, 8'h44, "R9");
    acc(1, 0, 16'hF000, 0, "R9");
    // R11 idle cycles
    acc(0, 1, 16'hFFFF, 8'h00, "R11");
    acc(0, 0, 16'h1000, 0, "R11");
    acc(1, 0, 16'hBFFF, 0, "R11");
    repeat (3) @(posedge clk);
    #1;
    chk(q.size() == 0, "R11 queue drained", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule